// File: doc/BRIEF.md
# Clock Source Select and Low-Power Control Register

This block is an 8-bit control register inside a clock and reset generator. Software programs it over a simple write/read port. It decides whether the system clock is taken from the oscillator or from the PLL. It also sets how the PLL, the oscillator, the real-time interrupt (RTI) divider chain and the watchdog (COP) counter behave while the device is in wait or stop mode. The register takes the PLL lock flag, the operating mode and the current power state as inputs. From these it drives the clock-source select, the PLL power-down, the oscillator enable and the freeze-and-clear controls for the RTI and the COP.

The register guards the clock source. Software can select the PLL only while the PLL reports lock. Hardware drops the PLL selection whenever the device runs on its self clock or is in stop mode. It also drops the selection in wait mode when software has asked for the PLL to stop there. The COP wait bit can be written once in normal mode and at any time in special mode. The oscillator configuration status is read through the same register and cannot be written. The selected clock feeds an external glitch-free mux, and the bus clock downstream is half of the selected clock.

Top module: `clksel_ctrl_reg`

## Requirements
- R1: After a synchronous reset, every writable bit reads 0 and the COP write-once latch is re-armed. rd_data then equals {2'b00, osc_cfg_ext, 5'b00000}.
- R2: A write with wr_data[7]=1 while pll_lock=0 leaves the PLL-select bit (read at bit 7) unchanged. With pll_lock=1 it sets the bit, and sel_pll follows from the next cycle.
- R3: While stop_mode or self_clock_mode is 1, the PLL-select bit is cleared at every clock edge.
- R4: While wait_mode=1 and the PLL-stop-in-wait bit (bit 3) is 1, pll_pwrdn=1 and PLL-select is cleared. After wait ends, PLL-select stays 0 until software writes it again. With bit 3 at 0, wait mode leaves PLL-select unchanged and pll_pwrdn=0.
- R5: If a write of 1 to PLL-select lands in the same cycle as a hardware clear condition, the bit ends at 0.
- R6: osc_enable is 0 only while stop_mode=1 and the pseudo-stop bit (bit 6) is 0. Otherwise it is 1.
- R7: rti_hold equals wait_mode AND the RTI-stop-in-wait bit (bit 1). cop_hold equals wait_mode AND the COP-stop-in-wait bit (bit 0).
- R8: With special_mode=0, only the first write after reset changes bit 0, and that first write uses up the chance even if it leaves the value the same. With special_mode=1, every write loads bit 0 and does not use up the normal-mode chance.
- R9: Bits 4 and 2 always read 0. Bit 5 always reads the current osc_cfg_ext input, and writes to it have no effect.
- R10: A write with wr_data[7]=0 always clears PLL-select when no hardware clear is active. Writes load bits 6, 3 and 1 without condition, visible on rd_data from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current register readback |
| pll_lock | input | 1 | PLL lock flag |
| special_mode | input | 1 | 1 = special (test) operating mode |
| osc_cfg_ext | input | 1 | Oscillator configuration status: 0 loop-controlled, 1 external/full-swing |
| stop_mode | input | 1 | Device is in stop mode |
| wait_mode | input | 1 | Device is in wait mode |
| self_clock_mode | input | 1 | Device runs on its self clock |
| sel_pll | output | 1 | 1 = system clock from PLL, 0 = from oscillator |
| pll_pwrdn | output | 1 | PLL power-down request |
| osc_enable | output | 1 | Oscillator enable |
| rti_hold | output | 1 | Freeze and clear the RTI dividers |
| cop_hold | output | 1 | Freeze and clear the COP counter |

## Verification
PLL-select writes are applied with lock high and with lock low. This separates a gated write from a write that is accepted. The writes are also applied before, during and after each of stop, self-clock and wait. This separates a hardware clear from a refused write, and shows whether the bit stays at 0 after wait exit. Write sequences for the COP bit are run in normal mode, in special mode and across a reset. These show whether the write-once latch is used up, bypassed and re-armed. A behavioural model is compared against every output on every clock.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
    localparam int REG_W    = 8;
    localparam int B_SEL    = 7;
    localparam int B_PSTOP  = 6;
    localparam int B_OSCCFG = 5;
    localparam int B_PLLWAI = 3;
    localparam int B_RTIWAI = 1;
    localparam int B_COPWAI = 0;
    localparam int N_PLAIN  = 3;
    localparam int PLAIN_POS [N_PLAIN] = '{B_PSTOP, B_PLLWAI, B_RTIWAI};

    typedef struct packed {
        logic sel;
        logic pstop;
        logic pllwai;
        logic rtiwai;
        logic copwai;
    } ctl_t;

    typedef struct packed {
        logic stop;
        logic wait_m;
        logic selfclk;
    } pwr_t;

    function automatic logic [REG_W-1:0] pack_read(input ctl_t c, input logic osc);
        logic [REG_W-1:0] r;
        r           = '0;
        r[B_SEL]    = c.sel;
        r[B_PSTOP]  = c.pstop;
        r[B_OSCCFG] = osc;
        r[B_PLLWAI] = c.pllwai;
        r[B_RTIWAI] = c.rtiwai;
        r[B_COPWAI] = c.copwai;
        return r;
    endfunction
endpackage

// File: rtl/clksel_rw_bit.sv
module clksel_rw_bit #(
    parameter int W   = 8,
    parameter int POS = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         q
);
    always_ff @(posedge clk) begin
        if (rst)        q <= 1'b0;
        else if (wr_en) q <= wr_data[POS];
    end
endmodule

// File: rtl/clksel_sel_bit.sv
module clksel_sel_bit (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_bit,
    input  logic pll_lock,
    input  logic hw_clr,
    output logic sel_q
);
    logic take_wr;

    // a one is accepted only under lock; a zero is always accepted
    assign take_wr = wr_en && (!wr_bit || pll_lock);

    always_ff @(posedge clk) begin
        if (rst)          sel_q <= 1'b0;
        else if (hw_clr)  sel_q <= 1'b0;
        else if (take_wr) sel_q <= wr_bit;
    end
endmodule

// File: rtl/clksel_once_bit.sv
module clksel_once_bit (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_bit,
    input  logic special_mode,
    output logic bit_q
);
    logic used_q;
    logic may_wr;

    assign may_wr = wr_en && (special_mode || !used_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q  <= 1'b0;
            used_q <= 1'b0;
        end else begin
            if (may_wr) bit_q <= wr_bit;
            if (wr_en && !special_mode) used_q <= 1'b1;
        end
    end
endmodule

// File: rtl/clksel_lp_ctrl.sv
module clksel_lp_ctrl
    import clksel_pkg::*;
(
    input  ctl_t ctl,
    input  pwr_t pwr,
    output logic hw_clr,
    output logic pll_pwrdn,
    output logic osc_enable,
    output logic rti_hold,
    output logic cop_hold
);
    always_comb begin
        pll_pwrdn  = pwr.wait_m && ctl.pllwai;
        hw_clr     = pwr.stop || pwr.selfclk || pll_pwrdn;
        osc_enable = !pwr.stop || ctl.pstop;
        rti_hold   = pwr.wait_m && ctl.rtiwai;
        cop_hold   = pwr.wait_m && ctl.copwai;
    end
endmodule

// File: rtl/clksel_ctrl_reg.sv
module clksel_ctrl_reg
    import clksel_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             pll_lock,
    input  logic             special_mode,
    input  logic             osc_cfg_ext,
    input  logic             stop_mode,
    input  logic             wait_mode,
    input  logic             self_clock_mode,
    output logic             sel_pll,
    output logic             pll_pwrdn,
    output logic             osc_enable,
    output logic             rti_hold,
    output logic             cop_hold
);
    ctl_t               ctl;
    pwr_t               pwr;
    logic               hw_clr;
    logic [N_PLAIN-1:0] plain_q;

    assign pwr = '{stop: stop_mode, wait_m: wait_mode, selfclk: self_clock_mode};

    for (genvar g = 0; g < N_PLAIN; g++) begin : g_plain
        clksel_rw_bit #(.W(REG_W), .POS(PLAIN_POS[g])) u_bit (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_en),
            .wr_data (wr_data),
            .q       (plain_q[g])
        );
    end

    clksel_sel_bit u_sel (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_bit   (wr_data[B_SEL]),
        .pll_lock (pll_lock),
        .hw_clr   (hw_clr),
        .sel_q    (ctl.sel)
    );

    clksel_once_bit u_cop (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_bit       (wr_data[B_COPWAI]),
        .special_mode (special_mode),
        .bit_q        (ctl.copwai)
    );

    assign ctl.pstop  = plain_q[0];
    assign ctl.pllwai = plain_q[1];
    assign ctl.rtiwai = plain_q[2];

    clksel_lp_ctrl u_lp (
        .ctl        (ctl),
        .pwr        (pwr),
        .hw_clr     (hw_clr),
        .pll_pwrdn  (pll_pwrdn),
        .osc_enable (osc_enable),
        .rti_hold   (rti_hold),
        .cop_hold   (cop_hold)
    );

    assign sel_pll = ctl.sel;
    assign rd_data = pack_read(ctl, osc_cfg_ext);
endmodule

// File: rtl/clksel_ctrl_reg_chk.sv
module clksel_ctrl_reg_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       pll_lock,
    input logic       special_mode,
    input logic       osc_cfg_ext,
    input logic       stop_mode,
    input logic       wait_mode,
    input logic       self_clock_mode,
    input logic       sel_pll,
    input logic       pll_pwrdn,
    input logic       osc_enable,
    input logic       rti_hold,
    input logic       cop_hold
);
    logic nw_seen;
    always_ff @(posedge clk) begin
        if (rst)                          nw_seen <= 1'b0;
        else if (wr_en && !special_mode)  nw_seen <= 1'b1;
    end

    p_lock_gate_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(sel_pll) |-> $past(wr_en && wr_data[7] && pll_lock));

    p_stop_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (stop_mode || self_clock_mode) |=> !sel_pll);

    p_wait_clear_r4: assert property (@(posedge clk) disable iff (rst)
        pll_pwrdn |=> !sel_pll);

    p_pwrdn_src_r4: assert property (@(posedge clk) disable iff (rst)
        pll_pwrdn |-> (wait_mode && rd_data[3]));

    p_osc_off_r6: assert property (@(posedge clk) disable iff (rst)
        !osc_enable |-> (stop_mode && !rd_data[6]));

    p_cop_hold_r7: assert property (@(posedge clk) disable iff (rst)
        cop_hold |-> wait_mode);

    p_cop_once_r8: assert property (@(posedge clk) disable iff (rst)
        (nw_seen && !special_mode) |=> $stable(rd_data[0]));

    p_unimpl_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_data[5] == osc_cfg_ext) && !rd_data[4] && !rd_data[2]);
endmodule

bind clksel_ctrl_reg clksel_ctrl_reg_chk u_chk (.*);

// File: tb/clksel_ctrl_reg_tb.sv
module clksel_ctrl_reg_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       pll_lock = 1'b0, special_mode = 1'b0, osc_cfg_ext = 1'b0;
    logic       stop_mode = 1'b0, wait_mode = 1'b0, self_clock_mode = 1'b0;
    logic       sel_pll, pll_pwrdn, osc_enable, rti_hold, cop_hold;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 0;

    // behavioural model state
    bit m_sel, m_pstop, m_pllwai, m_rtiwai, m_copwai, m_used;

    always #10 clk = ~clk;

    clksel_ctrl_reg u_dut (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] m_read();
        return {m_sel, m_pstop, osc_cfg_ext, 1'b0, m_pllwai, 1'b0, m_rtiwai, m_copwai};
    endfunction

    task automatic model_edge();
        bit clr;
        if (rst) begin
            {m_sel, m_pstop, m_pllwai, m_rtiwai, m_copwai, m_used} = '0;
        end else begin
            clr = stop_mode || self_clock_mode || (wait_mode && m_pllwai);
            if (wr_en) begin
                m_pstop  = wr_data[6];
                m_pllwai = wr_data[3];
                m_rtiwai = wr_data[1];
                if (special_mode || !m_used) m_copwai = wr_data[0];
                if (!special_mode) m_used = 1;
                if (!(wr_data[7] && !pll_lock)) m_sel = wr_data[7];
            end
            if (clr) m_sel = 0;
        end
    endtask

    task automatic compare();
        chk("R2/R3/R4/R5/R8/R9/R10 readback", rd_data, m_read());
        chk("R2 sel_pll", {7'b0, sel_pll}, {7'b0, m_sel});
        chk("R4 pll_pwrdn", {7'b0, pll_pwrdn}, {7'b0, wait_mode && m_pllwai});
        chk("R6 osc_enable", {7'b0, osc_enable}, {7'b0, !stop_mode || m_pstop});
        chk("R7 rti_hold", {7'b0, rti_hold}, {7'b0, wait_mode && m_rtiwai});
        chk("R7 cop_hold", {7'b0, cop_hold}, {7'b0, wait_mode && m_copwai});
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        cyc();
        wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        chk("R1 reset readback", rd_data, 8'h00);

        // R2: unlocked write of all ones, select refused, others loaded
        wr(8'hFF);
        chk("R2 locked-out select", rd_data & 8'h80, 8'h00);
        chk("R9 unimplemented bits", rd_data & 8'h34, 8'h00);
        // R8: second normal write cannot change COP bit
        wr(8'h00);
        chk("R8 write-once normal", rd_data & 8'h01, 8'h01);

        pll_lock = 1'b1;
        wr(8'h80);
        chk("R2 locked select", {7'b0, sel_pll}, 8'h01);
        wr(8'h00);
        chk("R10 zero write clears select", {7'b0, sel_pll}, 8'h00);
        wr(8'h80);
        pll_lock = 1'b0;
        wr(8'h80);
        chk("R2 unlocked write keeps one", {7'b0, sel_pll}, 8'h01);
        wr(8'h00);
        chk("R10 zero write without lock", {7'b0, sel_pll}, 8'h00);

        // R3 / R6: stop mode
        pll_lock = 1'b1;
        wr(8'h80);
        stop_mode = 1'b1;
        cyc();
        chk("R3 stop clears select", {7'b0, sel_pll}, 8'h00);
        chk("R6 osc off in stop", {7'b0, osc_enable}, 8'h00);
        // R5: write of one during stop
        wr(8'hC0);
        chk("R5 clear beats write", {7'b0, sel_pll}, 8'h00);
        chk("R6 pseudo stop keeps osc", {7'b0, osc_enable}, 8'h01);
        stop_mode = 1'b0;
        cyc();
        wr(8'h80);
        self_clock_mode = 1'b1;
        cyc();
        chk("R3 self clock clears select", {7'b0, sel_pll}, 8'h00);
        self_clock_mode = 1'b0;

        // R4: wait without and with PLL stop
        wr(8'h82);
        wait_mode = 1'b1;
        cyc(); cyc();
        chk("R4 wait keeps select when bit3=0", {7'b0, sel_pll}, 8'h01);
        chk("R7 rti hold in wait", {7'b0, rti_hold}, 8'h01);
        wait_mode = 1'b0;
        wr(8'h88);
        wait_mode = 1'b1;
        #1;
        chk("R4 pll power down", {7'b0, pll_pwrdn}, 8'h01);
        cyc();
        chk("R4 wait clears select", {7'b0, sel_pll}, 8'h00);
        wait_mode = 1'b0;
        cyc(); cyc();
        chk("R4 select stays 0 after wait", {7'b0, sel_pll}, 8'h00);

        // R8: special mode writes COP bit freely
        special_mode = 1'b1;
        wr(8'h00);
        chk("R8 special clears cop", rd_data & 8'h01, 8'h00);
        wr(8'h01);
        chk("R8 special sets cop", rd_data & 8'h01, 8'h01);
        wait_mode = 1'b1;
        cyc();
        chk("R7 cop hold in wait", {7'b0, cop_hold}, 8'h01);
        wait_mode = 1'b0;
        special_mode = 1'b0;
        wr(8'h00);
        chk("R8 normal latch already used", rd_data & 8'h01, 8'h01);

        // R9: status bit follows input, ignores writes
        osc_cfg_ext = 1'b1;
        wr(8'h00);
        chk("R9 status bit reads input", rd_data & 8'h20, 8'h20);
        osc_cfg_ext = 1'b0;
        wr(8'h20);
        chk("R9 status bit not writable", rd_data & 8'h20, 8'h00);

        // R1: reset re-arms the write-once latch
        rst = 1'b1;
        cyc();
        rst = 1'b0;
        chk("R1 reset clears all", rd_data, 8'h00);
        wr(8'h01);
        chk("R1 latch re-armed", rd_data & 8'h01, 8'h01);
        wr(8'h00);
        chk("R8 first write used latch", rd_data & 8'h01, 8'h01);
        repeat (4) cyc();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule